// File: doc/BRIEF.md
# Fixed-Point Matrix Multiply Engine

This block computes C = A x B for two small real matrices of signed 16-bit fixed-point numbers, using a single multiply-accumulate datapath that runs sequentially. Software or a host state machine first fills two on-chip operand arrays through a one-element-per-cycle write port. The largest supported shape is 8x8. It then gives the run-time dimensions M, N and P and pulses a start input. One result per output element is delivered on a 16-bit output with a single-cycle valid strobe, in row-major order.

Each element is summed in a 32-bit accumulator that wraps on overflow. The 16 output bits are a window cut from that accumulator. The window is placed relative to the accumulator binary point, which sits at R+S when A carries R fractional bits and B carries S. Five window modes are available: follow A's format, follow B's format, the top sixteen bits, the sixteen bits just below the sign, or a caller-chosen output fractional count F. No saturation or rounding is applied at any stage.

Top module: `fxmm_engine`

## Requirements
- R1: Each output element equals the sum over k of A[i][k]*B[k][j]. The products and the sum are signed and are reduced modulo 2^32. The accumulator is cleared before every element.
- R2: The mode is given by out_mode. Mode 0 gives F=R, mode 1 gives F=S and mode 4 gives F=frac_out. For these modes, out_data is accumulator bits [L+15:L] with L = R+S-F.
- R3: Mode 2, and any unused code from 5 to 7, outputs accumulator bits 31:16. Mode 3 outputs bits 30:15.
- R4: If L is negative, the accumulator is shifted left and zeros fill the vacated low output bits. Output bit positions that map above bit 31 take a copy of bit 31.
- R5: Neither accumulation nor window selection clamps. Bits outside the window are dropped, so an overflowing result wraps.
- R6: A run produces exactly M*P strobes in row-major order. Let E be the clock edge that accepts the start. Element e (counting from 0) is valid in the cycle that follows edge E+N+1+e*N, and out_valid is high for that one cycle.
- R7: busy rises at edge E and falls at the edge that raises the last out_valid of the run. busy is therefore low in the cycle of the final strobe.
- R8: While busy is high, start pulses and operand writes have no effect.
- R9: A start with any dimension equal to 0 or greater than 8, sampled while idle, sets err at that edge and leaves busy low, and no output follows. err stays high until the next accepted start clears it.
- R10: Dimensions, fractional counts and mode are sampled at the accepted start. Changes to them during a run do not affect that run.
- R11: While reset is held, busy, err and out_valid are low and out_data is zero.
- R12: A write with wr_sel=0 stores wr_data to A[wr_row][wr_col]. A write with wr_sel=1 stores it to B[wr_row][wr_col].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 1 | 0 selects A, 1 selects B |
| wr_row | input | 3 | Row of the element written |
| wr_col | input | 3 | Column of the element written |
| wr_data | input | 16 | Signed element value |
| start | input | 1 | Start pulse |
| dim_m | input | 4 | Rows of A |
| dim_n | input | 4 | Columns of A and rows of B |
| dim_p | input | 4 | Columns of B |
| frac_a | input | 5 | Fractional bits of A (R) |
| frac_b | input | 5 | Fractional bits of B (S) |
| out_mode | input | 3 | Window mode code |
| frac_out | input | 5 | Output fractional bits for mode 4 |
| busy | output | 1 | Run in progress |
| err | output | 1 | Last idle start had illegal dimensions |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Result element |

## Verification
Two things can happen in the same cycle: the final result of one run is emitted, and a new start or operand write is accepted, because busy has already dropped in that cycle. The bench waits for the exact cycle of the final strobe of a full 8x8x8 run and launches a second run there. The cycle-accurate model then expects the old run's last element, busy low in that cycle, busy high from the next edge, and the new run's strobes on their own schedule. A write and a start issued earlier in the busy window are judged by the later results, which must still use the old operands and configuration.

// File: rtl/fxmm_pkg.sv
package fxmm_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 32;
  localparam int FRAC_W = 5;
  localparam int LO_W   = 8;

  typedef enum logic [2:0] {
    OM_MATCH_A = 3'd0,
    OM_MATCH_B = 3'd1,
    OM_HI_ACC  = 3'd2,
    OM_HI_PROD = 3'd3,
    OM_USER    = 3'd4
  } omode_t;

  // Low accumulator index of the output window: L = R + S - F.
  function automatic logic signed [LO_W-1:0] lo_index(
      input logic [2:0]        mode,
      input logic [FRAC_W-1:0] fa,
      input logic [FRAC_W-1:0] fb,
      input logic [FRAC_W-1:0] fu);
    logic signed [LO_W-1:0] sa, sb, su;
    sa = $signed({{(LO_W-FRAC_W){1'b0}}, fa});
    sb = $signed({{(LO_W-FRAC_W){1'b0}}, fb});
    su = $signed({{(LO_W-FRAC_W){1'b0}}, fu});
    case (mode)
      OM_MATCH_A: lo_index = sb;
      OM_MATCH_B: lo_index = sa;
      OM_HI_PROD: lo_index = LO_W'(ACC_W - DATA_W - 1);
      OM_USER:    lo_index = sa + sb - su;
      default:    lo_index = LO_W'(ACC_W - DATA_W);
    endcase
  endfunction
endpackage

// File: rtl/fxmm_store.sv
module fxmm_store #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fxmm_ctrl.sv
module fxmm_ctrl #(
  parameter int MAX_DIM = 8,
  parameter int IDX_W   = 3,
  parameter int DIM_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] dim_m,
  input  logic [DIM_W-1:0] dim_n,
  input  logic [DIM_W-1:0] dim_p,
  output logic             launch,
  output logic             busy,
  output logic             err,
  output logic [IDX_W-1:0] rd_i,
  output logic [IDX_W-1:0] rd_k,
  output logic [IDX_W-1:0] rd_j,
  output logic             mac_v,
  output logic             mac_first,
  output logic             mac_last
);
  localparam logic [DIM_W-1:0] DMAX = DIM_W'(MAX_DIM);
  localparam logic [DIM_W-1:0] ONE  = DIM_W'(1);

  logic             dims_ok;
  logic [DIM_W-1:0] m_l, n_l, p_l;
  logic [IDX_W-1:0] ci, ck, cj;
  logic             iss_act, k_end, j_end, i_end;
  logic             v1, first1, last1, fin1;
  logic             busy_q, err_q;

  assign dims_ok = (dim_m != '0) && (dim_m <= DMAX) &&
                   (dim_n != '0) && (dim_n <= DMAX) &&
                   (dim_p != '0) && (dim_p <= DMAX);
  assign launch  = start && !busy_q && dims_ok;

  assign k_end = (DIM_W'(ck) == n_l - ONE);
  assign j_end = (DIM_W'(cj) == p_l - ONE);
  assign i_end = (DIM_W'(ci) == m_l - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_l <= '0; n_l <= '0; p_l <= '0;
      ci <= '0; ck <= '0; cj <= '0;
      iss_act <= 1'b0;
      v1 <= 1'b0; first1 <= 1'b0; last1 <= 1'b0; fin1 <= 1'b0;
      busy_q <= 1'b0; err_q <= 1'b0;
    end else begin
      v1     <= iss_act;
      first1 <= iss_act && (ck == '0);
      last1  <= iss_act && k_end;
      fin1   <= iss_act && k_end && j_end && i_end;
      if (iss_act) begin
        if (!k_end) ck <= ck + 1'b1;
        else begin
          ck <= '0;
          if (!j_end) cj <= cj + 1'b1;
          else begin
            cj <= '0;
            if (!i_end) ci <= ci + 1'b1;
            else iss_act <= 1'b0;
          end
        end
      end
      if (fin1) busy_q <= 1'b0;
      if (launch) begin
        m_l <= dim_m; n_l <= dim_n; p_l <= dim_p;
        ci <= '0; ck <= '0; cj <= '0;
        iss_act <= 1'b1;
        busy_q  <= 1'b1;
        err_q   <= 1'b0;
      end else if (start && !busy_q && !dims_ok) begin
        err_q <= 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign err       = err_q;
  assign rd_i      = ci;
  assign rd_k      = ck;
  assign rd_j      = cj;
  assign mac_v     = v1;
  assign mac_first = first1;
  assign mac_last  = last1;

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !busy_q);

  // R6
  mac_idle_chk: assert property (@(posedge clk) disable iff (rst)
    v1 |-> busy_q);
endmodule

// File: rtl/fxmm_window.sv
module fxmm_window #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  parameter int LO_W  = 8
) (
  input  logic [ACC_W-1:0]       acc,
  input  logic signed [LO_W-1:0] lo,
  output logic [OUT_W-1:0]       win
);
  logic [LO_W-1:0]  amt_l, amt_r;
  logic [ACC_W-1:0] sh;

  assign amt_l = $unsigned(-lo);
  assign amt_r = $unsigned(lo);

  always_comb begin
    if (lo[LO_W-1]) sh = acc << amt_l;
    else            sh = $unsigned($signed(acc) >>> amt_r);
  end

  assign win = sh[OUT_W-1:0];
endmodule

// File: rtl/fxmm_engine.sv
module fxmm_engine
  import fxmm_pkg::*;
#(
  parameter int MAX_DIM = 8,
  parameter int IDX_W   = $clog2(MAX_DIM),
  parameter int DIM_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [IDX_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [DIM_W-1:0]  dim_m,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  dim_p,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  input  logic [2:0]        out_mode,
  input  logic [FRAC_W-1:0] frac_out,
  output logic              busy,
  output logic              err,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int AW = 2 * IDX_W;

  logic             launch;
  logic [IDX_W-1:0] rd_i, rd_k, rd_j;
  logic             mac_v, mac_first, mac_last;
  logic [DATA_W-1:0] a_q, b_q;
  logic             a_we, b_we;
  logic signed [ACC_W-1:0] prod;
  logic [ACC_W-1:0] acc, acc_next;
  logic signed [LO_W-1:0] lo_l;
  logic [DATA_W-1:0] win;

  fxmm_ctrl #(.MAX_DIM(MAX_DIM), .IDX_W(IDX_W), .DIM_W(DIM_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .dim_m(dim_m), .dim_n(dim_n), .dim_p(dim_p),
    .launch(launch), .busy(busy), .err(err),
    .rd_i(rd_i), .rd_k(rd_k), .rd_j(rd_j),
    .mac_v(mac_v), .mac_first(mac_first), .mac_last(mac_last)
  );

  assign a_we = wr_en && !busy && !wr_sel;
  assign b_we = wr_en && !busy &&  wr_sel;

  // Address {row, col} assumes MAX_DIM is a power of two.
  fxmm_store #(.DATA_W(DATA_W), .AW(AW)) a_store_i (
    .clk(clk), .we(a_we), .waddr({wr_row, wr_col}), .wdata(wr_data),
    .raddr({rd_i, rd_k}), .rdata(a_q)
  );

  fxmm_store #(.DATA_W(DATA_W), .AW(AW)) b_store_i (
    .clk(clk), .we(b_we), .waddr({wr_row, wr_col}), .wdata(wr_data),
    .raddr({rd_k, rd_j}), .rdata(b_q)
  );

  assign prod     = ACC_W'($signed(a_q)) * ACC_W'($signed(b_q));
  assign acc_next = (mac_first ? '0 : acc) + $unsigned(prod);

  fxmm_window #(.ACC_W(ACC_W), .OUT_W(DATA_W), .LO_W(LO_W)) window_i (
    .acc(acc_next), .lo(lo_l), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      lo_l      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (launch) lo_l <= lo_index(out_mode, frac_a, frac_b, frac_out);
      if (mac_v) acc <= acc_next;
      out_valid <= mac_v && mac_last;
      if (mac_v && mac_last) out_data <= win;
    end
  end

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  // R7
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(lo_l));

  // R1
  acc_first_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mac_v && mac_first) |-> (acc == $unsigned($past(prod))));
endmodule

// File: tb/fxmm_engine_tb_top.sv
module fxmm_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        wr_en, wr_sel, start;
  logic [2:0]  wr_row, wr_col, out_mode;
  logic [15:0] wr_data;
  logic [3:0]  dim_m, dim_n, dim_p;
  logic [4:0]  frac_a, frac_b, frac_out;
  logic        busy, err, out_valid;
  logic [15:0] out_data;

  fxmm_engine dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .start(start),
    .dim_m(dim_m), .dim_n(dim_n), .dim_p(dim_p),
    .frac_a(frac_a), .frac_b(frac_b), .out_mode(out_mode), .frac_out(frac_out),
    .busy(busy), .err(err), .out_valid(out_valid), .out_data(out_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  logic signed [15:0] ma [8][8];
  logic signed [15:0] mb [8][8];
  int          cq[$];
  logic [15:0] dq[$];
  string       tq[$];
  int b_lo = -1, b_hi = -2;
  bit err_old = 0, err_new = 0;
  int err_cyc = 0;

  function automatic bit exp_busy(int c);
    return (c >= b_lo) && (c <= b_hi);
  endfunction

  function automatic bit exp_err(int c);
    return (c >= err_cyc) ? err_new : err_old;
  endfunction

  function automatic int lo_ref(int md, int fa, int fb, int fu);
    case (md)
      0: return fb;
      1: return fa;
      3: return 15;
      4: return fa + fb - fu;
      default: return 16;
    endcase
  endfunction

  function automatic logic [15:0] win_ref(logic [31:0] a, int lo);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      int idx = lo + b;
      if (idx < 0)       r[b] = 1'b0;
      else if (idx > 31) r[b] = a[31];
      else               r[b] = a[idx];
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ev;
      check(busy === exp_busy(cyc), "R7", "busy", longint'(busy), longint'(exp_busy(cyc)));
      check(err === exp_err(cyc), "R9", "err", longint'(err), longint'(exp_err(cyc)));
      while (cq.size() > 0 && cq[0] < cyc) begin
        check(0, tq[0], "result never seen", 0, longint'(dq[0]));
        void'(cq.pop_front()); void'(dq.pop_front()); void'(tq.pop_front());
      end
      ev = (cq.size() > 0) && (cq[0] == cyc);
      if (!ev && out_valid !== 1'b0)
        check(0, "R6", "unexpected out_valid", longint'(out_valid), 0);
      else if (ev) begin
        if (out_valid !== 1'b1) check(0, tq[0], "missing out_valid", longint'(out_valid), 1);
        else check(out_data === dq[0], tq[0], "out_data", longint'(out_data), longint'(dq[0]));
        void'(cq.pop_front()); void'(dq.pop_front()); void'(tq.pop_front());
      end
    end
  end

  // All tasks are entered just after a falling edge.
  task automatic wr(bit sel, int r, int c, logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_row = r[2:0]; wr_col = c[2:0]; wr_data = d;
    if (!exp_busy(cyc)) begin
      if (sel) mb[r][c] = d; else ma[r][c] = d;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic launch(int m, int n, int p, int fa, int fb, int fu, int md, string tag);
    int e0 = cyc + 1;
    dim_m = m[3:0]; dim_n = n[3:0]; dim_p = p[3:0];
    frac_a = fa[4:0]; frac_b = fb[4:0]; frac_out = fu[4:0]; out_mode = md[2:0];
    start = 1;
    if (!exp_busy(cyc)) begin
      bit ok = (m >= 1 && m <= 8 && n >= 1 && n <= 8 && p >= 1 && p <= 8);
      err_old = exp_err(cyc);
      err_cyc = e0;
      err_new = !ok;
      if (ok) begin
        int lo = lo_ref(md, fa, fb, fu);
        for (int i = 0; i < m; i++)
          for (int j = 0; j < p; j++) begin
            logic signed [31:0] acc = 0;
            for (int k = 0; k < n; k++) acc = acc + ma[i][k] * mb[k][j];
            cq.push_back(e0 + n + 1 + (i * p + j) * n);
            dq.push_back(win_ref(acc, lo));
            tq.push_back(tag);
          end
        b_lo = e0;
        b_hi = e0 + m * n * p;
      end
    end
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (exp_busy(cyc) || cq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R7 watchdog: actual running expected idle");
      summary();
      $finish;
    end
  end

  initial begin
    int hi_end;
    rst = 1; wr_en = 0; wr_sel = 0; wr_row = 0; wr_col = 0; wr_data = 0;
    start = 0; dim_m = 1; dim_n = 1; dim_p = 1;
    frac_a = 0; frac_b = 0; frac_out = 0; out_mode = 0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin ma[r][c] = 'x; mb[r][c] = 'x; end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy === 0, "R11", "busy in reset", longint'(busy), 0);
    check(err === 0, "R11", "err in reset", longint'(err), 0);
    check(out_valid === 0, "R11", "out_valid in reset", longint'(out_valid), 0);
    check(out_data === 0, "R11", "out_data in reset", longint'(out_data), 0);
    rst = 0;
    @(negedge clk);

    // R12: load 2x2 operands through both selects
    wr(0, 0, 0, 16'sd16384); wr(0, 0, 1, -16'sd8192);
    wr(0, 1, 0, 16'sd32767); wr(0, 1, 1, 16'sd100);
    wr(1, 0, 0, 16'sd16384); wr(1, 0, 1, 16'sd16384);
    wr(1, 1, 0, -16'sd32768); wr(1, 1, 1, 16'sd5);

    // R2 / R1: Q15 operands in match-A, match-B, user modes
    launch(2, 2, 2, 15, 15, 0, 0, "R2");  wait_idle();
    launch(2, 2, 2, 15, 15, 0, 1, "R2");  wait_idle();
    launch(2, 2, 2, 15, 15, 10, 4, "R2"); wait_idle();
    launch(2, 2, 2, 3, 5, 0, 0, "R2");    wait_idle();
    launch(2, 2, 2, 3, 5, 0, 1, "R2");    wait_idle();
    // R3: fixed windows and unused codes
    launch(2, 2, 2, 15, 15, 0, 2, "R3");  wait_idle();
    launch(2, 2, 2, 15, 15, 0, 3, "R3");  wait_idle();
    launch(2, 2, 2, 1, 2, 0, 6, "R3");    wait_idle();
    // R4: negative low index and sign copy above bit 31
    launch(2, 2, 2, 0, 0, 20, 4, "R4");   wait_idle();
    launch(2, 2, 2, 15, 15, 0, 4, "R4");  wait_idle();
    launch(2, 2, 2, 31, 31, 0, 4, "R4");  wait_idle();

    // R5: accumulator wrap and window wrap
    for (int k = 0; k < 8; k++) begin wr(0, 0, k, 16'h8000); wr(1, k, 0, 16'h8000); end
    launch(1, 2, 1, 0, 0, 0, 2, "R5");    wait_idle();
    launch(1, 8, 1, 0, 0, 0, 2, "R5");    wait_idle();
    wr(0, 1, 0, 16'sd300); wr(1, 0, 1, 16'sd300);
    launch(2, 1, 2, 0, 0, 0, 4, "R5");    wait_idle();

    // R9: illegal dimensions, then a legal start clears err
    launch(0, 2, 2, 0, 0, 0, 2, "R9");    repeat (4) @(negedge clk);
    launch(9, 1, 1, 0, 0, 0, 2, "R9");    repeat (4) @(negedge clk);
    launch(1, 1, 1, 0, 0, 0, 2, "R9");    wait_idle();

    // R6 / R1: full-size random run
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        wr(0, r, c, 16'($urandom));
        wr(1, r, c, 16'($urandom));
      end
    launch(8, 8, 8, 7, 9, 0, 0, "R6");
    hi_end = b_hi;
    // R8: write and start while busy are ignored; R10: config changes do not matter
    repeat (20) @(negedge clk);
    wr(0, 0, 0, 16'h1234);
    wr(1, 0, 0, 16'h4321);
    launch(2, 2, 2, 0, 0, 3, 4, "R8");
    launch(0, 0, 0, 0, 0, 3, 4, "R8");
    frac_a = 5'd1; frac_b = 5'd2; out_mode = 3'd3; // R10
    // Start again in the cycle of the final strobe
    while (cyc != hi_end + 1) @(negedge clk);
    launch(3, 4, 2, 2, 4, 0, 1, "R6");
    wait_idle();
    // R8: operands unchanged by the writes issued while busy
    launch(1, 1, 1, 0, 0, 0, 4, "R8");
    wait_idle();
    launch(1, 1, 1, 0, 0, 16, 4, "R1");
    wait_idle();

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule